// File: doc/BRIEF.md
# Cached Memory Request Bus Controller

This block is a hardwired state machine that serves one processor memory request at a time. A read first passes two check cycles. In these the memory-cycle permit, the cache permit and the cache hit flag are sampled. A read that hits completes locally. A read that misses, or that has no cache permit, goes out on a shared arbitrated bus. A write skips the cache checks and always goes to the bus, provided the memory-cycle permit is set. When a request has no permit, the controller aborts it and returns to idle.

On the bus, the controller raises the start request and the bus request together. It holds both until arbitration reports it is master and its own start is taken. It then watches mastership, the acknowledge and a 2-bit reply code. From these it decides whether to keep waiting, to advance the block-read address, to re-arbitrate, to finish, or to stop in an error state. Each error state holds until reset, and in it the cycle-ending strobe stays asserted so that the processor is not left waiting. All outputs are decoded from the registered state.

Top module: `mreq_bus_ctrl`

## Requirements
- R1: After reset the controller is idle. All drive enables, the bus requests, the hit enable, the address controls and the error flag are 0. The cache mode is 0 (none). `noted_no` and `ending_no` are 1. `err_kind_o` is 0.
- R2: In idle, a request with `clk_full_i` high is dispatched: to the read path when `wr_i` is 0, and to the write path when `wr_i` is 1. While `clk_full_i` is 0 the controller stays idle.
- R3: A read or write that finds `mem_permit_i` low at its check aborts. It holds `noted_no` and `ending_no` low for one cycle, then spends one settle cycle with both high, then returns to idle.
- R4: A read presents cache mode 0 in its first cycle and cache mode 1 in its two check cycles. The second check cycle also raises `hit_en_o`. With no cache permit the read goes to the bus. With cache permit, a hit at the second check completes locally: `noted_no` and `ending_no` go low for one cycle, followed by one settle cycle. A miss goes to the bus.
- R5: In the arbitration state, `start_req_o` and `bus_req_o` are both 1. They stay 1 until a clock edge sees `master_ni` and `mystart_ni` both low. After that edge both are 0.
- R6: While master with no acknowledge, the controller keeps waiting. On a read, a reply code with bit 0 set and no acknowledge, outside the first wait cycle, pulses `addr_inc_o`. Read wait cycles drive `addr_from_bus_o`.
- R7: With master and acknowledge high, the reply code is decoded as follows: 0 = retry, 1 = timeout, 2 = error, 3 = complete. Retry spends one idle-like cycle and then arbitrates again. Complete drives `ending_no` low for one cycle and then returns to idle.
- R8: If `dmaster_i` is low during any completion-wait cycle, the controller enters the lost-master error state.
- R9: The timeout, bus-error and lost-master states are sticky. In them `error_o` is 1, `ending_no` is 0, and all bus requests and drive enables are 0, whatever the inputs do.
- R10: The cache mode is 2 (write on bus transfer) in the read cycle where the start is taken, in every later read wait cycle, and in the write wait cycles. Mode 3 never appears.
- R11: `noted_no` goes low for one cycle. For a read this is the cycle right after the start is taken. For a write it is the first completion-wait cycle, which comes two cycles after the start is taken.
- R12: `err_kind_o` reports the terminal error reached: 1 = lost master, 2 = timeout, 3 = bus error. It appears in the same cycle as `error_o` and is cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Memory request pending |
| wr_i | input | 1 | Request is a write |
| clk_full_i | input | 1 | Clock running at full speed |
| mem_permit_i | input | 1 | Memory cycle permitted |
| cache_permit_i | input | 1 | Cache lookup permitted |
| cache_hit_i | input | 1 | Cache hit |
| master_ni | input | 1 | Arbitration: master, active low |
| mystart_ni | input | 1 | Arbitration: own start taken, active low |
| dmaster_i | input | 1 | Currently bus master (synchronized) |
| ack_i | input | 1 | Bus acknowledge |
| tm_i | input | 2 | Bus reply code |
| start_req_o | output | 1 | Start request to arbiter |
| bus_req_o | output | 1 | Bus request to arbiter |
| md_to_bus_o | output | 1 | Drive write data onto the bus |
| rd_to_bus_o | output | 1 | Route bus read data |
| cache_mode_o | output | 2 | Cache mode: 0 none, 1 read, 2 write on transfer, 3 write if hit |
| noted_no | output | 1 | Request noted, active low |
| ending_no | output | 1 | Memory cycle ending, active low |
| addr_from_bus_o | output | 1 | Cache address from the bus address |
| addr_inc_o | output | 1 | Advance the block-read bus address |
| hit_en_o | output | 1 | Cache hit enable |
| error_o | output | 1 | Sticky error state |
| err_kind_o | output | 2 | Terminal error kind |

## Verification
Every output is decoded from the state register, so each result is due exactly one clock edge after the edge that samples its stimulus. A request seen at one edge shows the first read or write cycle after it. A grant seen at one edge drops both requests after it. A read's request-noted pulse follows that same edge, and a write's follows it by two edges. A reply decoded at one edge shows its completion, retry or error state after it. The bench drives inputs just after each falling edge. Its behavioural model advances on the rising edge, and every output is compared against the model at the next falling edge. Stimulus and sampling therefore sit half a period apart from the edge that moves the state.

// File: rtl/mreq_pkg.sv
package mreq_pkg;
  localparam int unsigned REPLY_W = 2;
  localparam int unsigned KIND_W  = 2;
  localparam int unsigned MODE_W  = 2;
  localparam int unsigned STATE_W = 5;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE, ST_RD_REQ, ST_RD_CHK1, ST_RD_CHK2, ST_ABORT, ST_HIT, ST_SETTLE,
    ST_RD_ARB, ST_RD_GO, ST_RD_WAIT, ST_RD_BLK, ST_RD_RETRY, ST_RD_DONE,
    ST_WR_REQ, ST_WR_ARB, ST_WR_GO, ST_WR_FIRST, ST_WR_WAIT, ST_WR_RETRY,
    ST_WR_DONE, ST_ERR_LOST, ST_ERR_TMO, ST_ERR_BUS
  } ctl_state_e;

  typedef enum logic [MODE_W-1:0] {
    CM_NONE = 2'd0, CM_READ = 2'd1, CM_WR_XFER = 2'd2, CM_WR_HIT = 2'd3
  } cache_mode_e;

  typedef enum logic [KIND_W-1:0] {
    EK_NONE = 2'd0, EK_LOST = 2'd1, EK_TMO = 2'd2, EK_BUS = 2'd3
  } err_kind_e;

  typedef enum logic [REPLY_W-1:0] {
    RP_RETRY = 2'd0, RP_TMO = 2'd1, RP_ERR = 2'd2, RP_DONE = 2'd3
  } reply_e;

  typedef struct packed {
    logic        start_req;
    logic        bus_req;
    logic        md_drv;
    logic        rd_drv;
    cache_mode_e mode;
    logic        noted_n;
    logic        ending_n;
    logic        adr_from_bus;
    logic        adr_inc;
    logic        hit_en;
    logic        err;
  } ctl_out_t;
endpackage

// File: rtl/mreq_reply.sv
module mreq_reply
  import mreq_pkg::*;
#(
  parameter bit IS_READ = 1'b1
) (
  input  logic               first_i,
  input  logic               dmaster_i,
  input  logic               ack_i,
  input  logic [REPLY_W-1:0] tm_i,
  output ctl_state_e         nxt_o
);
  localparam ctl_state_e WAIT_ST  = IS_READ ? ST_RD_WAIT  : ST_WR_WAIT;
  localparam ctl_state_e RETRY_ST = IS_READ ? ST_RD_RETRY : ST_WR_RETRY;
  localparam ctl_state_e DONE_ST  = IS_READ ? ST_RD_DONE  : ST_WR_DONE;

  always_comb begin
    if (!dmaster_i) begin
      nxt_o = ST_ERR_LOST;
    end else if (!ack_i) begin
      // intermediate block ack only on reads, never on the first wait cycle
      nxt_o = (IS_READ && !first_i && tm_i[0]) ? ST_RD_BLK : WAIT_ST;
    end else begin
      unique case (reply_e'(tm_i))
        RP_RETRY: nxt_o = RETRY_ST;
        RP_TMO:   nxt_o = ST_ERR_TMO;
        RP_ERR:   nxt_o = ST_ERR_BUS;
        default:  nxt_o = DONE_ST;
      endcase
    end
  end
endmodule

// File: rtl/mreq_next.sv
module mreq_next
  import mreq_pkg::*;
(
  input  ctl_state_e         state_q,
  input  logic               req_i,
  input  logic               wr_i,
  input  logic               clk_full_i,
  input  logic               mem_permit_i,
  input  logic               cache_permit_i,
  input  logic               cache_hit_i,
  input  logic               master_ni,
  input  logic               mystart_ni,
  input  logic               dmaster_i,
  input  logic               ack_i,
  input  logic [REPLY_W-1:0] tm_i,
  output ctl_state_e         state_d
);
  localparam int unsigned NDIR = 2;  // 0 read, 1 write

  ctl_state_e reply_nxt [NDIR];
  logic       first_w   [NDIR];
  logic       granted;

  assign first_w[0] = (state_q == ST_RD_GO);
  assign first_w[1] = (state_q == ST_WR_FIRST);
  assign granted    = !master_ni && !mystart_ni;

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    mreq_reply #(.IS_READ(g == 0)) u_reply (
      .first_i   (first_w[g]),
      .dmaster_i (dmaster_i),
      .ack_i     (ack_i),
      .tm_i      (tm_i),
      .nxt_o     (reply_nxt[g])
    );
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:
        if (req_i && clk_full_i) state_d = wr_i ? ST_WR_REQ : ST_RD_REQ;
      ST_RD_REQ:  state_d = ST_RD_CHK1;
      ST_RD_CHK1:
        if (!mem_permit_i)        state_d = ST_ABORT;
        else if (!cache_permit_i) state_d = ST_RD_ARB;
        else                      state_d = ST_RD_CHK2;
      ST_RD_CHK2:
        if (!mem_permit_i)                       state_d = ST_ABORT;
        else if (cache_permit_i && cache_hit_i)  state_d = ST_HIT;
        else                                     state_d = ST_RD_ARB;
      ST_ABORT, ST_HIT: state_d = ST_SETTLE;
      ST_SETTLE:        state_d = ST_IDLE;
      ST_RD_ARB:  if (granted) state_d = ST_RD_GO;
      ST_RD_GO, ST_RD_WAIT, ST_RD_BLK: state_d = reply_nxt[0];
      ST_RD_RETRY: state_d = ST_RD_ARB;
      ST_RD_DONE:  state_d = ST_IDLE;
      ST_WR_REQ:   state_d = mem_permit_i ? ST_WR_ARB : ST_ABORT;
      ST_WR_ARB:   if (granted) state_d = ST_WR_GO;
      ST_WR_GO:    state_d = ST_WR_FIRST;
      ST_WR_FIRST, ST_WR_WAIT: state_d = reply_nxt[1];
      ST_WR_RETRY: state_d = ST_WR_ARB;
      ST_WR_DONE:  state_d = ST_IDLE;
      default:     state_d = state_q;  // terminal error states hold
    endcase
  end
endmodule

// File: rtl/mreq_decode.sv
module mreq_decode
  import mreq_pkg::*;
(
  input  ctl_state_e state_q,
  output ctl_out_t   out_o
);
  always_comb begin
    out_o          = '0;
    out_o.mode     = CM_NONE;
    out_o.noted_n  = 1'b1;
    out_o.ending_n = 1'b1;
    unique case (state_q)
      ST_RD_CHK1: out_o.mode = CM_READ;
      ST_RD_CHK2: begin out_o.mode = CM_READ; out_o.hit_en = 1'b1; end
      ST_ABORT, ST_HIT: begin out_o.noted_n = 1'b0; out_o.ending_n = 1'b0; end
      ST_RD_ARB: begin
        out_o.start_req = 1'b1; out_o.bus_req = 1'b1; out_o.rd_drv = 1'b1;
      end
      ST_RD_GO: begin
        out_o.rd_drv = 1'b1; out_o.noted_n = 1'b0; out_o.mode = CM_WR_XFER;
      end
      ST_RD_WAIT: begin
        out_o.rd_drv = 1'b1; out_o.mode = CM_WR_XFER; out_o.adr_from_bus = 1'b1;
      end
      ST_RD_BLK: begin
        out_o.rd_drv = 1'b1; out_o.mode = CM_WR_XFER;
        out_o.adr_from_bus = 1'b1; out_o.adr_inc = 1'b1;
      end
      ST_RD_DONE: begin out_o.rd_drv = 1'b1; out_o.ending_n = 1'b0; end
      ST_WR_REQ, ST_WR_GO: out_o.md_drv = 1'b1;
      ST_WR_ARB: begin
        out_o.start_req = 1'b1; out_o.bus_req = 1'b1; out_o.md_drv = 1'b1;
      end
      ST_WR_FIRST: begin
        out_o.md_drv = 1'b1; out_o.noted_n = 1'b0; out_o.mode = CM_WR_XFER;
      end
      ST_WR_WAIT: begin out_o.md_drv = 1'b1; out_o.mode = CM_WR_XFER; end
      ST_WR_DONE: begin out_o.md_drv = 1'b1; out_o.ending_n = 1'b0; end
      ST_ERR_LOST, ST_ERR_TMO, ST_ERR_BUS: begin
        out_o.err = 1'b1; out_o.ending_n = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mreq_err_track.sv
module mreq_err_track
  import mreq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  ctl_state_e state_d,
  output err_kind_e  kind_o
);
  err_kind_e kind_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= EK_NONE;
    end else if (kind_q == EK_NONE) begin
      unique case (state_d)
        ST_ERR_LOST: kind_q <= EK_LOST;
        ST_ERR_TMO:  kind_q <= EK_TMO;
        ST_ERR_BUS:  kind_q <= EK_BUS;
        default:     kind_q <= EK_NONE;
      endcase
    end
  end

  assign kind_o = kind_q;
endmodule

// File: rtl/mreq_bus_ctrl.sv
module mreq_bus_ctrl
  import mreq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               wr_i,
  input  logic               clk_full_i,
  input  logic               mem_permit_i,
  input  logic               cache_permit_i,
  input  logic               cache_hit_i,
  input  logic               master_ni,
  input  logic               mystart_ni,
  input  logic               dmaster_i,
  input  logic               ack_i,
  input  logic [REPLY_W-1:0] tm_i,
  output logic               start_req_o,
  output logic               bus_req_o,
  output logic               md_to_bus_o,
  output logic               rd_to_bus_o,
  output logic [MODE_W-1:0]  cache_mode_o,
  output logic               noted_no,
  output logic               ending_no,
  output logic               addr_from_bus_o,
  output logic               addr_inc_o,
  output logic               hit_en_o,
  output logic               error_o,
  output logic [KIND_W-1:0]  err_kind_o
);
  ctl_state_e state_q, state_d;
  ctl_out_t   outs;
  err_kind_e  kind;

  mreq_next u_next (
    .state_q        (state_q),
    .req_i          (req_i),
    .wr_i           (wr_i),
    .clk_full_i     (clk_full_i),
    .mem_permit_i   (mem_permit_i),
    .cache_permit_i (cache_permit_i),
    .cache_hit_i    (cache_hit_i),
    .master_ni      (master_ni),
    .mystart_ni     (mystart_ni),
    .dmaster_i      (dmaster_i),
    .ack_i          (ack_i),
    .tm_i           (tm_i),
    .state_d        (state_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  mreq_decode u_decode (
    .state_q (state_q),
    .out_o   (outs)
  );

  mreq_err_track u_err (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_d (state_d),
    .kind_o  (kind)
  );

  assign start_req_o     = outs.start_req;
  assign bus_req_o       = outs.bus_req;
  assign md_to_bus_o     = outs.md_drv;
  assign rd_to_bus_o     = outs.rd_drv;
  assign cache_mode_o    = outs.mode;
  assign noted_no        = outs.noted_n;
  assign ending_no       = outs.ending_n;
  assign addr_from_bus_o = outs.adr_from_bus;
  assign addr_inc_o      = outs.adr_inc;
  assign hit_en_o        = outs.hit_en;
  assign error_o         = outs.err;
  assign err_kind_o      = kind;
endmodule

// File: rtl/mreq_bus_ctrl_chk.sv
module mreq_bus_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       master_ni,
  input logic       mystart_ni,
  input logic       start_req_o,
  input logic       bus_req_o,
  input logic       rd_to_bus_o,
  input logic [1:0] cache_mode_o,
  input logic       noted_no,
  input logic       ending_no,
  input logic       addr_inc_o,
  input logic       error_o,
  input logic [1:0] err_kind_o
);
  p_abort_settle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!noted_no && !ending_no) |=> (noted_no && ending_no));

  p_grant_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_req_o && !master_ni && !mystart_ni) |=> (!start_req_o && !bus_req_o));

  p_arb_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_req_o && (master_ni || mystart_ni)) |=> (start_req_o && bus_req_o));

  p_inc_in_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_inc_o |-> (rd_to_bus_o && cache_mode_o == 2'd2));

  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |=> (error_o && !ending_no && !start_req_o));

  p_no_mode3_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cache_mode_o != 2'd3);

  p_noted_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !noted_no |=> noted_no);

  p_kind_with_err_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> (err_kind_o != 2'd0));

  p_kind_stable_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_kind_o != 2'd0) |=> $stable(err_kind_o));
endmodule

bind mreq_bus_ctrl mreq_bus_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .master_ni    (master_ni),
  .mystart_ni   (mystart_ni),
  .start_req_o  (start_req_o),
  .bus_req_o    (bus_req_o),
  .rd_to_bus_o  (rd_to_bus_o),
  .cache_mode_o (cache_mode_o),
  .noted_no     (noted_no),
  .ending_no    (ending_no),
  .addr_inc_o   (addr_inc_o),
  .error_o      (error_o),
  .err_kind_o   (err_kind_o)
);

// File: tb/mreq_bus_ctrl_bench.sv
`timescale 1ns/1ps
module mreq_bus_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic req = 0, wr = 0, full = 1, mp = 1, cp = 1, hit = 0;
  logic mn = 1, msn = 1, dm = 1, ack = 0;
  logic [1:0] tm = 2'd0;

  logic start_req, bus_req, md_drv, rd_drv, noted_n, ending_n;
  logic afb, inc, hit_en, err;
  logic [1:0] mode, kind;

  mreq_bus_ctrl u_mreq_bus_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_i(wr), .clk_full_i(full),
    .mem_permit_i(mp), .cache_permit_i(cp), .cache_hit_i(hit),
    .master_ni(mn), .mystart_ni(msn), .dmaster_i(dm), .ack_i(ack), .tm_i(tm),
    .start_req_o(start_req), .bus_req_o(bus_req), .md_to_bus_o(md_drv),
    .rd_to_bus_o(rd_drv), .cache_mode_o(mode), .noted_no(noted_n),
    .ending_no(ending_n), .addr_from_bus_o(afb), .addr_inc_o(inc),
    .hit_en_o(hit_en), .error_o(err), .err_kind_o(kind)
  );

  // model state codes
  localparam int M_IDLE = 0, M_RREQ = 1, M_RC1 = 2, M_RC2 = 3, M_ABORT = 4,
                 M_HIT = 5, M_SETTLE = 6, M_RARB = 7, M_RGO = 8, M_RWAIT = 9,
                 M_RBLK = 10, M_RRETRY = 11, M_RDONE = 12, M_WREQ = 13,
                 M_WARB = 14, M_WGO = 15, M_WFIRST = 16, M_WWAIT = 17,
                 M_WRETRY = 18, M_WDONE = 19, M_ELOST = 20, M_ETMO = 21, M_EBUS = 22;

  int m_st = M_IDLE;
  int m_kind = 0;
  int checks = 0, errors = 0;
  bit after_reset = 1'b1;

  function automatic int reply_next(bit is_rd, bit first);
    if (!dm) return M_ELOST;
    if (!ack) return (is_rd && !first && tm[0]) ? M_RBLK : (is_rd ? M_RWAIT : M_WWAIT);
    case (tm)
      2'd0: return is_rd ? M_RRETRY : M_WRETRY;
      2'd1: return M_ETMO;
      2'd2: return M_EBUS;
      default: return is_rd ? M_RDONE : M_WDONE;
    endcase
  endfunction

  function automatic int model_next(int s);
    case (s)
      M_IDLE:   return (req && full) ? (wr ? M_WREQ : M_RREQ) : M_IDLE;
      M_RREQ:   return M_RC1;
      M_RC1:    return !mp ? M_ABORT : (!cp ? M_RARB : M_RC2);
      M_RC2:    return !mp ? M_ABORT : ((cp && hit) ? M_HIT : M_RARB);
      M_ABORT, M_HIT: return M_SETTLE;
      M_SETTLE: return M_IDLE;
      M_RARB:   return (!mn && !msn) ? M_RGO : M_RARB;
      M_RGO:    return reply_next(1, 1);
      M_RWAIT, M_RBLK: return reply_next(1, 0);
      M_RRETRY: return M_RARB;
      M_RDONE:  return M_IDLE;
      M_WREQ:   return mp ? M_WARB : M_ABORT;
      M_WARB:   return (!mn && !msn) ? M_WGO : M_WARB;
      M_WGO:    return M_WFIRST;
      M_WFIRST, M_WWAIT: return reply_next(0, 0);
      M_WRETRY: return M_WARB;
      M_WDONE:  return M_IDLE;
      default:  return s;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = M_IDLE;
      m_kind = 0;
    end else begin
      m_st = model_next(m_st);
      if (m_kind == 0) begin
        if (m_st == M_ELOST) m_kind = 1;
        else if (m_st == M_ETMO) m_kind = 2;
        else if (m_st == M_EBUS) m_kind = 3;
      end
    end
  end

  function automatic string tag_of(int s);
    case (s)
      M_IDLE: return "R2";
      M_ABORT, M_SETTLE: return "R3";
      M_RREQ, M_RC1, M_RC2, M_HIT: return "R4";
      M_RARB, M_WARB: return "R5";
      M_RWAIT, M_RBLK, M_WWAIT: return "R6";
      M_ELOST: return "R8";
      M_ETMO, M_EBUS: return "R9";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(string tag, string name, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s state=%0d actual=%0d expected=%0d at %0t",
               tag, name, m_st, act, exp, $time);
    end
  endtask

  task automatic compare();
    int e_start = 0, e_md = 0, e_rd = 0, e_mode = 0, e_n = 1, e_end = 1;
    int e_afb = 0, e_inc = 0, e_hit = 0, e_err = 0;
    string t = after_reset ? "R1" : tag_of(m_st);
    case (m_st)
      M_RC1:  e_mode = 1;
      M_RC2:  begin e_mode = 1; e_hit = 1; end
      M_ABORT, M_HIT: begin e_n = 0; e_end = 0; end
      M_RARB: begin e_start = 1; e_rd = 1; end
      M_RGO:  begin e_rd = 1; e_n = 0; e_mode = 2; end
      M_RWAIT: begin e_rd = 1; e_mode = 2; e_afb = 1; end
      M_RBLK: begin e_rd = 1; e_mode = 2; e_afb = 1; e_inc = 1; end
      M_RDONE: begin e_rd = 1; e_end = 0; end
      M_WREQ, M_WGO: e_md = 1;
      M_WARB: begin e_start = 1; e_md = 1; end
      M_WFIRST: begin e_md = 1; e_n = 0; e_mode = 2; end
      M_WWAIT: begin e_md = 1; e_mode = 2; end
      M_WDONE: begin e_md = 1; e_end = 0; end
      M_ELOST, M_ETMO, M_EBUS: begin e_err = 1; e_end = 0; end
      default: ;
    endcase
    chk(t, "start_req", start_req, e_start);
    chk(t, "bus_req", bus_req, e_start);
    chk(t, "md_to_bus", md_drv, e_md);
    chk(t, "rd_to_bus", rd_drv, e_rd);
    chk(after_reset ? "R1" : "R10", "cache_mode", mode, e_mode);
    chk((m_st == M_RGO || m_st == M_WFIRST) ? "R11" : t, "noted_n", noted_n, e_n);
    chk(t, "ending_n", ending_n, e_end);
    chk(t, "addr_from_bus", afb, e_afb);
    chk(t, "addr_inc", inc, e_inc);
    chk(t, "hit_en", hit_en, e_hit);
    chk(t, "error", err, e_err);
    chk(after_reset ? "R1" : "R12", "err_kind", kind, m_kind);
    after_reset = 1'b0;
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req = 0; wr = 0; full = 1; mp = 1; cp = 1; hit = 0;
    mn = 1; msn = 1; dm = 1; ack = 0; tm = 2'd0;
    after_reset = 1'b1;
    step(1);
    rst_n = 1'b1;
    after_reset = 1'b1;
    step(1);
  endtask

  task automatic grant();
    mn = 0; msn = 0;
    step(1);
    mn = 1; msn = 1;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R2: not at full speed, request ignored
    full = 0; req = 1; step(3);
    full = 1; step(1); req = 0; step(1);
    // R3: read with no memory permit
    mp = 0; step(4); mp = 1;
    // R4, R5, R6: read to bus without cache permit, block acks
    cp = 0; req = 1; step(1); req = 0; step(3);
    grant(); step(1);
    tm = 2'd1; step(1);
    tm = 2'd3; step(1);
    tm = 2'd2; step(1);
    ack = 1; tm = 2'd3; step(1);   // R7 complete
    ack = 0; tm = 2'd0; step(2);
    // R4: cache hit completes locally
    cp = 1; hit = 1; req = 1; step(1); req = 0; step(5);
    // R4 miss then R7 retry
    hit = 0; req = 1; step(1); req = 0; step(3);
    grant(); ack = 1; tm = 2'd0; step(1);
    ack = 0; step(2);
    grant(); ack = 1; tm = 2'd3; step(1);
    ack = 0; tm = 2'd0; step(2);
    // write path to completion
    wr = 1; req = 1; step(1); req = 0; step(2);
    grant(); step(2);
    tm = 2'd1; step(1);
    ack = 1; tm = 2'd3; step(1);
    ack = 0; tm = 2'd0; step(2);
    // write abort (R3)
    mp = 0; req = 1; step(1); req = 0; step(3);
    mp = 1; wr = 0;
    // R9 timeout sticky
    cp = 0; req = 1; step(1); req = 0; step(2);
    grant(); ack = 1; tm = 2'd1; step(1);
    ack = 0; req = 1; mn = 0; msn = 0; step(4);
    do_reset();
    // R9/R12 bus error on write
    wr = 1; req = 1; step(1); req = 0; step(2);
    grant(); step(1);
    ack = 1; tm = 2'd2; step(1);
    ack = 1; tm = 2'd3; step(3);
    do_reset();
    // R8 lost master on read
    cp = 0; req = 1; step(1); req = 0; step(2);
    grant(); step(1);
    dm = 0; step(1); dm = 1; ack = 1; tm = 2'd3; step(3);
    do_reset();
    step(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule